// File: doc/BRIEF.md
# Subarray-Interleaved Refresh Command Sequencer

This block refreshes one bundle of DRAM rows. A one-cycle start pulse carries a bundle index. The block then issues a dummy activate followed by a precharge for every row in the bundle. No read or write is issued between the two commands of a row. Each command leaves the block as a single-cycle strobe with an opcode and its bank, subarray and row fields. A done pulse follows once the last row has been closed.

Two placement modes are available. In sequential mode, every row of the bundle lives in one subarray. A row's activate then has to wait until the previous row has finished both its active time and its precharge time. In scattered mode, row k goes to subarray k modulo the subarray count. The next activate can then go out while earlier subarrays are still open or still precharging, so the bundle finishes far sooner.

The command port has no back-pressure. A memory-side controller is expected to accept a command on every cycle in which the valid strobe is high. The low BANK_W bits of the bundle index select the bank. The remaining high bits, called the group, select the rows.

Top module: `rfsh_seq`

## Requirements
- R1: After reset, busy, done and command valid are all low.
- R2: Every row of the bundle gets one activate (opcode 0) and then one precharge (opcode 1) with the same subarray and row. The precharge appears exactly T_RAS cycles after that activate. Exactly ROWS activates are issued per bundle.
- R3: In sequential mode (scatter input low), all rows use subarray group mod NSUB. Row k uses row (group / NSUB) * ROWS + k. Successive activates are T_RAS + T_RP cycles apart.
- R4: In scattered mode (scatter input high), row k uses subarray k mod NSUB and row group * (ROWS / NSUB) + k / NSUB.
- R5: Successive activates are never closer than T_RRD cycles. In scattered mode, with no collision, they are exactly T_RRD apart, and the first activate appears one cycle after the cycle in which start is captured.
- R6: When a precharge and an activate fall due in the same cycle, the precharge is issued and the activate moves to the next cycle.
- R7: Done pulses for exactly one cycle, one cycle after the last precharge of the bundle. Busy is high from the cycle after start is captured until that last precharge, and it is low in the done cycle.
- R8: A start pulse that arrives while busy is high is ignored. The running bundle's fields and timing are not disturbed, and no extra done is produced.
- R9: At most one command is issued per cycle, and no command is issued while busy is low.
- R10: The bank field equals the low BANK_W bits of the captured bundle index and stays constant for the whole bundle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to refresh a bundle |
| bundle_i | input | BUNDLE_W | Bundle index, captured with start |
| scatter_i | input | 1 | 1 selects scattered placement, 0 selects sequential; captured with start |
| busy_o | output | 1 | A bundle is in progress |
| done_o | output | 1 | One-cycle pulse after the last precharge |
| cmd_valid_o | output | 1 | A command is present this cycle |
| cmd_op_o | output | 1 | 0 = activate, 1 = precharge |
| cmd_bank_o | output | BANK_W | Bank field |
| cmd_sub_o | output | $clog2(NSUB) | Subarray field |
| cmd_row_o | output | ROW_W | Row field |

## Verification
The assertions assume that start is a clean synchronous pulse and that reset is held low across at least one clock edge. They also assume that nothing downstream ever stalls a command, because the command port has no ready input. The stimulus drives every input on falling edges. It raises start only as a single-cycle pulse, and it lets each bundle finish before the next is requested, apart from the deliberate mid-bundle start. A second instance, built with an even active time, is used so that precharge/activate collisions actually occur.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {SEQ_IDLE = 2'd0, SEQ_RUN = 2'd1, SEQ_DRAIN = 2'd2} seq_state_e;
  typedef enum logic [1:0] {SUB_IDLE = 2'd0, SUB_OPEN = 2'd1, SUB_PRECH = 2'd2} sub_state_e;
  localparam logic OP_ACT = 1'b0;
  localparam logic OP_PRE = 1'b1;
endpackage

// File: rtl/rfsh_sub_timer.sv
module rfsh_sub_timer #(
  parameter int T_RAS = 5,
  parameter int T_RP  = 3,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             pre_due_o,
  output logic             act_ok_o,
  output logic [ROW_W-1:0] row_o
);
  import rfsh_pkg::*;
  localparam int TMAX = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int CW   = $clog2(TMAX + 1) + 1;
  localparam logic [CW-1:0] RAS_C = CW'(T_RAS);
  localparam logic [CW-1:0] RP_C  = CW'(T_RP);

  sub_state_e       st;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SUB_IDLE;
      cnt   <= '0;
      row_q <= '0;
    end else if (act_i) begin
      st    <= SUB_OPEN;
      cnt   <= CW'(1);
      row_q <= row_i;
    end else if (pre_i) begin
      st  <= SUB_PRECH;
      cnt <= CW'(1);
    end else begin
      case (st)
        SUB_OPEN:  if (cnt < RAS_C) cnt <= cnt + CW'(1);
        SUB_PRECH: if (cnt >= RP_C) st <= SUB_IDLE;
                   else cnt <= cnt + CW'(1);
        default:   cnt <= cnt;
      endcase
    end
  end

  assign pre_due_o = (st == SUB_OPEN) && (cnt >= RAS_C);
  assign act_ok_o  = (st == SUB_IDLE) || ((st == SUB_PRECH) && (cnt >= RP_C));
  assign row_o     = row_q;
endmodule

// File: rtl/rfsh_addr_map.sv
module rfsh_addr_map #(
  parameter int ROWS  = 16,
  parameter int NSUB  = 8,
  parameter int GRP_W = 6,
  parameter int ROW_W = 9
) (
  input  logic [GRP_W-1:0]          grp_i,
  input  logic [$clog2(ROWS)-1:0]   k_i,
  input  logic                      scatter_i,
  output logic [$clog2(NSUB)-1:0]   sub_o,
  output logic [ROW_W-1:0]          row_o
);
  localparam int SUB_W = $clog2(NSUB);
  localparam int RPS   = ROWS / NSUB;

  always_comb begin
    if (scatter_i) begin
      sub_o = k_i[SUB_W-1:0];
      row_o = ROW_W'(grp_i) * ROW_W'(RPS) + ROW_W'(k_i >> SUB_W);
    end else begin
      sub_o = grp_i[SUB_W-1:0];
      row_o = ROW_W'(grp_i >> SUB_W) * ROW_W'(ROWS) + ROW_W'(k_i);
    end
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq #(
  parameter int ROWS     = 16,
  parameter int NSUB     = 8,
  parameter int BANK_W   = 2,
  parameter int BUNDLE_W = 8,
  parameter int ROW_W    = 9,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int T_RRD    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [BUNDLE_W-1:0]     bundle_i,
  input  logic                    scatter_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    cmd_valid_o,
  output logic                    cmd_op_o,
  output logic [BANK_W-1:0]       cmd_bank_o,
  output logic [$clog2(NSUB)-1:0] cmd_sub_o,
  output logic [ROW_W-1:0]        cmd_row_o
);
  import rfsh_pkg::*;
  localparam int SUB_W = $clog2(NSUB);
  localparam int KI_W  = $clog2(ROWS);
  localparam int CNT_W = $clog2(ROWS + 1);
  localparam int GRP_W = BUNDLE_W - BANK_W;
  localparam int RRD_W = $clog2(T_RRD + 1) + 1;
  localparam logic [CNT_W-1:0] ROWS_C = CNT_W'(ROWS);
  localparam logic [RRD_W-1:0] RRD_C  = RRD_W'(T_RRD);

  seq_state_e       st;
  logic [GRP_W-1:0]  grp_q;
  logic [BANK_W-1:0] bank_q;
  logic              scat_q;
  logic [CNT_W-1:0]  act_cnt, pre_cnt;
  logic [RRD_W-1:0]  rrd_cnt;
  logic              done_q;

  logic [NSUB-1:0]   pre_due, act_ok, act_v, pre_v;
  logic [ROW_W-1:0]  sub_row [NSUB];
  logic [SUB_W-1:0]  tgt_sub, pre_sel;
  logic [ROW_W-1:0]  tgt_row;
  logic              pre_go, act_go;

  rfsh_addr_map #(.ROWS(ROWS), .NSUB(NSUB), .GRP_W(GRP_W), .ROW_W(ROW_W)) u_map (
    .grp_i(grp_q), .k_i(act_cnt[KI_W-1:0]), .scatter_i(scat_q),
    .sub_o(tgt_sub), .row_o(tgt_row)
  );

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign act_v[g] = act_go && (tgt_sub == SUB_W'(g));
    assign pre_v[g] = pre_go && (pre_sel == SUB_W'(g));
    rfsh_sub_timer #(.T_RAS(T_RAS), .T_RP(T_RP), .ROW_W(ROW_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .act_i(act_v[g]), .pre_i(pre_v[g]),
      .row_i(tgt_row), .pre_due_o(pre_due[g]), .act_ok_o(act_ok[g]),
      .row_o(sub_row[g])
    );
  end

  always_comb begin
    pre_sel = '0;
    for (int i = NSUB - 1; i >= 0; i--)
      if (pre_due[i]) pre_sel = SUB_W'(i);
  end

  assign pre_go = |pre_due;
  assign act_go = (st == SEQ_RUN) && !pre_go && (act_cnt < ROWS_C) &&
                  act_ok[tgt_sub] && (rrd_cnt >= RRD_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      grp_q   <= '0;
      bank_q  <= '0;
      scat_q  <= 1'b0;
      act_cnt <= '0;
      pre_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        SEQ_IDLE: if (start_i) begin
          st      <= SEQ_RUN;
          bank_q  <= bundle_i[BANK_W-1:0];
          grp_q   <= bundle_i[BUNDLE_W-1:BANK_W];
          scat_q  <= scatter_i;
          act_cnt <= '0;
          pre_cnt <= '0;
        end
        SEQ_RUN: begin
          if (act_go) act_cnt <= act_cnt + CNT_W'(1);
          if (pre_go) begin
            pre_cnt <= pre_cnt + CNT_W'(1);
            if (pre_cnt == ROWS_C - CNT_W'(1)) st <= SEQ_DRAIN;
          end
        end
        default: begin
          st     <= SEQ_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rrd_cnt <= RRD_C;
    else if (act_go) rrd_cnt <= RRD_W'(1);
    else if (rrd_cnt < RRD_C) rrd_cnt <= rrd_cnt + RRD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= OP_ACT;
      cmd_sub_o   <= '0;
      cmd_row_o   <= '0;
    end else begin
      cmd_valid_o <= act_go || pre_go;
      cmd_op_o    <= pre_go ? OP_PRE : OP_ACT;
      cmd_sub_o   <= pre_go ? pre_sel : tgt_sub;
      cmd_row_o   <= pre_go ? sub_row[pre_sel] : tgt_row;
    end
  end

  assign busy_o     = (st != SEQ_IDLE);
  assign done_o     = done_q;
  assign cmd_bank_o = bank_q;
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int BANK_W = 2,
  parameter int SUB_W  = 3,
  parameter int ROW_W  = 9,
  parameter int T_RRD  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              cmd_valid_o,
  input logic              cmd_op_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [SUB_W-1:0]  cmd_sub_o,
  input logic [ROW_W-1:0]  cmd_row_o
);
  localparam int GW = $clog2(T_RRD + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= GW'(T_RRD);
    else if (cmd_valid_o && !cmd_op_o) gap <= GW'(1);
    else if (gap < GW'(T_RRD)) gap <= gap + GW'(1);
  end

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_op_o) |-> (gap >= GW'(T_RRD))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(cmd_valid_o) && $past(cmd_op_o) && !busy_o)); // R7
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(cmd_bank_o)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !done_o && cmd_valid_o) |=> (busy_o || done_o)); // R8
  AST_FIELDS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> !$isunknown({cmd_sub_o, cmd_row_o})); // R2
endmodule

bind rfsh_seq rfsh_seq_chk #(
  .BANK_W(BANK_W), .SUB_W($clog2(NSUB)), .ROW_W(ROW_W), .T_RRD(T_RRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_bank_o(cmd_bank_o),
  .cmd_sub_o(cmd_sub_o), .cmd_row_o(cmd_row_o)
);

// File: tb/rfsh_seq_bench.sv
module rfsh_seq_bench;
  localparam int ROWS = 16, NSUB = 8, BANK_W = 2, BUNDLE_W = 8, ROW_W = 9;
  localparam int T_RAS = 5, T_RP = 3, T_RRD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, scat = 1'b0;
  logic [BUNDLE_W-1:0] bundle = '0;
  logic busy, done, cv, cop;
  logic [BANK_W-1:0] cbank;
  logic [2:0] csub;
  logic [ROW_W-1:0] crow;

  logic start2 = 1'b0;
  logic busy2, done2, cv2, cop2;
  logic [BANK_W-1:0] cbank2;
  logic [2:0] csub2;
  logic [ROW_W-1:0] crow2;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rfsh_seq #(.ROWS(ROWS), .NSUB(NSUB), .BANK_W(BANK_W), .BUNDLE_W(BUNDLE_W),
    .ROW_W(ROW_W), .T_RAS(T_RAS), .T_RP(T_RP), .T_RRD(T_RRD)) u_rfsh_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bundle_i(bundle), .scatter_i(scat),
    .busy_o(busy), .done_o(done), .cmd_valid_o(cv), .cmd_op_o(cop),
    .cmd_bank_o(cbank), .cmd_sub_o(csub), .cmd_row_o(crow));

  rfsh_seq #(.ROWS(ROWS), .NSUB(NSUB), .BANK_W(BANK_W), .BUNDLE_W(BUNDLE_W),
    .ROW_W(ROW_W), .T_RAS(4), .T_RP(T_RP), .T_RRD(T_RRD)) u_rfsh_col (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .bundle_i(8'h00), .scatter_i(1'b1),
    .busy_o(busy2), .done_o(done2), .cmd_valid_o(cv2), .cmd_op_o(cop2),
    .cmd_bank_o(cbank2), .cmd_sub_o(csub2), .cmd_row_o(crow2));

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R1", busy, 0, "busy after reset");
    check("R1", done, 0, "done after reset");
    check("R1", cv, 0, "cmd valid after reset");
  endtask

  // Runs one bundle on the main instance and checks every cycle against the schedule.
  task automatic t_bundle(input logic s, input logic [7:0] b, input bit glitch);
    int step = s ? T_RRD : (T_RAS + T_RP);
    int last_pre = 1 + T_RAS + (ROWS - 1) * step;
    int grp = b >> BANK_W;
    int acts = 0, dones = 0;
    @(negedge clk); start = 1'b1; bundle = b; scat = s;
    @(negedge clk); start = 1'b0; bundle = 8'hFF; scat = ~s;
    for (int n = 0; n <= last_pre + 3; n++) begin
      bit ea = (n >= 1) && ((n - 1) % step == 0) && ((n - 1) / step < ROWS);
      bit ep = (n >= 1 + T_RAS) && ((n - 1 - T_RAS) % step == 0) && ((n - 1 - T_RAS) / step < ROWS);
      int k = ea ? (n - 1) / step : (n - 1 - T_RAS) / step;
      int esub = s ? k % NSUB : grp % NSUB;
      int erow = s ? grp * (ROWS / NSUB) + k / NSUB : (grp / NSUB) * ROWS + k;
      string rq = ep ? "R2" : (ea ? (s ? "R4" : "R3") : "R9");
      check(rq, cv, (ea || ep) ? 1 : 0, $sformatf("valid at n=%0d", n));
      if (ea || ep) begin
        check(rq, cop, ep ? 1 : 0, $sformatf("opcode at n=%0d", n));
        check(rq, csub, esub, $sformatf("subarray at n=%0d", n));
        check(rq, crow, erow, $sformatf("row at n=%0d", n));
        check("R10", cbank, b & 3, $sformatf("bank at n=%0d", n));
      end
      check("R7", busy, (n <= last_pre) ? 1 : 0, $sformatf("busy at n=%0d", n));
      check("R7", done, (n == last_pre + 1) ? 1 : 0, $sformatf("done at n=%0d", n));
      if (cv && !cop) acts++;
      if (done) dones++;
      if (glitch && n == 10) begin start = 1'b1; bundle = 8'hFF; end
      if (glitch && n == 11) start = 1'b0;
      @(negedge clk);
    end
    check("R2", acts, ROWS, "activate count");
    check(glitch ? "R8" : "R7", dones, 1, "done count");
    repeat (4) @(negedge clk);
  endtask

  task automatic t_collision();
    @(negedge clk); start2 = 1'b1;
    @(negedge clk); start2 = 1'b0;
    for (int n = 0; n <= 8; n++) begin
      // T_RAS=4: ACT n1 s0, n3 s1; PRE s0 at n5 pushes ACT s2 to n6; PRE s1 n7; ACT s3 n8
      int ev = (n == 1 || n == 3 || n == 5 || n == 6 || n == 7 || n == 8) ? 1 : 0;
      int eop = (n == 5 || n == 7) ? 1 : 0;
      int es = (n == 1 || n == 5) ? 0 : (n == 3 || n == 7) ? 1 : (n == 6) ? 2 : 3;
      check("R6", cv2, ev, $sformatf("collision valid at n=%0d", n));
      if (ev == 1) begin
        check("R6", cop2, eop, $sformatf("collision opcode at n=%0d", n));
        check("R6", csub2, es, $sformatf("collision subarray at n=%0d", n));
      end
      @(negedge clk);
    end
    for (int i = 0; i < 200 && busy2; i++) @(negedge clk);
    check("R6", busy2, 0, "collision bundle completes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bundle(1'b1, 8'hB6, 1'b0);
    t_bundle(1'b0, 8'hD3, 1'b0);
    t_bundle(1'b1, 8'h05, 1'b1);
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule